// File: doc/BRIEF.md
# Threshold Byte FIFO with Interrupt Status

This block is a byte-wide FIFO between a host register port and a serial transfer engine. A direction bit decides which side fills it. In receive direction the engine pushes bytes and the host pops them through the data register. In transmit direction the host pushes through the data register and the engine pops them. The engine sees the head byte at all times, together with full and empty flags.

A sticky status register collects events. The FIFO-request bit is set while the receive level is above a programmable threshold, or while the transmit FIFO has drained to its fixed threshold. Other bits record misuse of the data port, events reported by the engine, and transfer completion. Writing ones to the status register clears those bits. A mask register selects which status bits drive the interrupt line. Writing the clear command empties the FIFO. That command bit reads back as set until the flush has taken effect.

The parameter `INCLUSIVE` selects how the threshold is compared. It also sets the transmit threshold to 0 (inclusive) or 1 (exclusive). In both cases the transmit request fires on an empty FIFO.

Top module: `xfer_fifo_irq`

## Requirements
- R1: After reset the FIFO is empty, `irq` is low, and the registers read as follows: control (address 0) 0x01 (receive direction), threshold (address 1) DEPTH-1, status (address 2) 0x00, mask (address 3) 0x00.
- R2: Bytes leave in the order they entered. In receive direction, engine pushes are returned by host reads of the data register (address 4). The read data is valid one cycle after the read strobe. In transmit direction, host data writes appear on `engPopData` in order.
- R3: A host data write in transmit direction while the FIFO holds DEPTH bytes sets status bit 4 (overflow). The byte is dropped.
- R4: A host data read in receive direction while the FIFO is empty sets status bit 3 (underflow) and returns 0x00.
- R5: A data-register access against the direction sets status bit 2 (illegal operation). This covers a write in receive direction and a read in transmit direction. Such an access moves no data, and a read of this kind returns 0x00.
- R6: In receive direction, status bit 0 (FIFO request) is set while the level is greater than the threshold. With INCLUSIVE=1 it is set while the level is greater than or equal to the threshold.
- R7: In transmit direction, status bit 0 is set while the FIFO is empty.
- R8: Writing a value to status address 2 clears every bit written as 1 and leaves the others unchanged. A condition that still holds in that cycle wins over the clear.
- R9: Writing control bit 1 empties the FIFO. Bit 1 reads back as 1 in the cycle after the write and as 0 once the flush is done. Control bit 0 sets the direction: 1 selects receive, 0 selects transmit.
- R10: The engine event inputs set status bits on the next clock edge: `engDone` sets bit 1, `engArbLost` sets bit 5, `engNack` sets bit 6 and `engBusFault` sets bit 7.
- R11: `irq` is high exactly when some status bit and its mask bit (address 3) are both 1.
- R12: An engine pop in receive direction and an engine push in transmit direction are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| hostWr | input | 1 | Host register write strobe |
| hostRd | input | 1 | Host register read strobe |
| hostAddr | input | 3 | Register address: 0 control, 1 threshold, 2 status, 3 mask, 4 data |
| hostWdata | input | 8 | Host write data |
| hostRdata | output | 8 | Registered read data, valid the cycle after `hostRd` |
| engPush | input | 1 | Engine push strobe (receive direction) |
| engPushData | input | 8 | Byte pushed by the engine |
| engPop | input | 1 | Engine pop strobe (transmit direction) |
| engPopData | output | 8 | Head byte of the FIFO |
| engFull | output | 1 | FIFO holds DEPTH bytes |
| engEmpty | output | 1 | FIFO holds no byte |
| engDone | input | 1 | Transfer complete event |
| engArbLost | input | 1 | Arbitration error event |
| engNack | input | 1 | Missing acknowledge event |
| engBusFault | input | 1 | Bus error event |
| irq | output | 1 | Masked interrupt request |

## Verification
A pointer or level that has drifted shows within one pop: `engPopData` or the returned data register carries the wrong byte. The full and empty flags also flip at the wrong count, which the overflow and underflow bits reveal one cycle later. A request comparison that is off by one appears as status bit 0 being set one push early or one push late. A flush that does not complete shows as control bit 1 staying high on the second read, or as `engEmpty` staying low. Errors in the status or mask logic reach `irq` in the same cycle the register changes.

// File: rtl/xfer_fifo_pkg.sv
package xfer_fifo_pkg;

  typedef struct packed {
    logic push;
    logic pop;
    logic flush;
    logic hostSrc;
  } fifoStrobe_t;

  localparam int ST_REQ     = 0;
  localparam int ST_DONE    = 1;
  localparam int ST_ILLEGAL = 2;
  localparam int ST_UNDER   = 3;
  localparam int ST_OVER    = 4;
  localparam int ST_ARB     = 5;
  localparam int ST_NACK    = 6;
  localparam int ST_BUS     = 7;

  localparam logic [2:0] REG_CTRL  = 3'd0;
  localparam logic [2:0] REG_THRES = 3'd1;
  localparam logic [2:0] REG_STAT  = 3'd2;
  localparam logic [2:0] REG_MASK  = 3'd3;
  localparam logic [2:0] REG_DATA  = 3'd4;

endpackage

// File: rtl/xfer_fifo_store.sv
module xfer_fifo_store
  import xfer_fifo_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rstN,
  input  fifoStrobe_t   stb,
  input  logic [7:0]    hostData,
  input  logic [7:0]    engData,
  output logic [7:0]    headData,
  output logic [CW-1:0] level,
  output logic          full,
  output logic          empty
);

  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [7:0]    mem [DEPTH];
  logic [PW-1:0] wrPtr, rdPtr;
  logic [CW-1:0] count;
  logic [7:0]    inData;

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign inData = stb.hostSrc ? hostData : engData;

  always_ff @(posedge clk) begin
    if (!rstN || stb.flush) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (stb.push) wrPtr <= bump(wrPtr);
      if (stb.pop)  rdPtr <= bump(rdPtr);
      case ({stb.push, stb.pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (stb.push && !stb.flush) mem[wrPtr] <= inData;
  end

  assign headData = mem[rdPtr];
  assign level    = count;
  assign full     = (count == CW'(DEPTH));
  assign empty    = (count == '0);

  // R3: control never pushes into a full store
  a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rstN)
    stb.push |-> !full);

  // R4: control never pops an empty store
  a_r4_no_underflow: assert property (@(posedge clk) disable iff (!rstN)
    stb.pop |-> !empty);

  // R9: a flush leaves the store empty
  a_r9_flush_empties: assert property (@(posedge clk) disable iff (!rstN)
    stb.flush |=> empty);

endmodule

// File: rtl/xfer_fifo_ctrl.sv
module xfer_fifo_ctrl
  import xfer_fifo_pkg::*;
#(
  parameter int DEPTH     = 16,
  parameter int INCLUSIVE = 0,
  parameter int CW        = $clog2(DEPTH + 1),
  parameter int TW        = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          hostWr,
  input  logic          hostRd,
  input  logic [2:0]    hostAddr,
  input  logic [7:0]    hostWdata,
  output logic [7:0]    hostRdata,
  input  logic          engPush,
  input  logic          engPop,
  input  logic          engDone,
  input  logic          engArbLost,
  input  logic          engNack,
  input  logic          engBusFault,
  input  logic [CW-1:0] level,
  input  logic          full,
  input  logic          empty,
  input  logic [7:0]    headData,
  output fifoStrobe_t   stb,
  output logic          irq
);

  localparam logic [CW-1:0] TX_THRES = (INCLUSIVE != 0) ? CW'(0) : CW'(1);

  logic          dirRx;
  logic          clearBusy;
  logic [TW-1:0] rxThres;
  logic [7:0]    status, mask;
  logic [7:0]    setVec, clrVec;
  logic          dataRd, dataWr, reqCond;

  assign dataRd = hostRd && (hostAddr == REG_DATA);
  assign dataWr = hostWr && (hostAddr == REG_DATA);

  always_comb begin
    stb       = '0;
    stb.flush = clearBusy;
    if (!clearBusy) begin
      if (dirRx) begin
        stb.push = engPush && !full;
        stb.pop  = dataRd && !empty;
      end else begin
        stb.hostSrc = 1'b1;
        stb.push    = dataWr && !full;
        stb.pop     = engPop && !empty;
      end
    end
  end

  generate
    if (INCLUSIVE != 0) begin : g_incl
      assign reqCond = dirRx ? (level >= CW'(rxThres)) : (level <= TX_THRES);
    end else begin : g_excl
      assign reqCond = dirRx ? (level > CW'(rxThres)) : (level < TX_THRES);
    end
  endgenerate

  always_comb begin
    setVec             = '0;
    setVec[ST_REQ]     = reqCond;
    setVec[ST_DONE]    = engDone;
    setVec[ST_ILLEGAL] = (dataRd && !dirRx) || (dataWr && dirRx);
    setVec[ST_UNDER]   = dataRd && dirRx && empty;
    setVec[ST_OVER]    = dataWr && !dirRx && full;
    setVec[ST_ARB]     = engArbLost;
    setVec[ST_NACK]    = engNack;
    setVec[ST_BUS]     = engBusFault;
    clrVec = (hostWr && hostAddr == REG_STAT) ? hostWdata : 8'h00;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      dirRx     <= 1'b1;
      clearBusy <= 1'b0;
      rxThres   <= TW'(DEPTH - 1);
      status    <= '0;
      mask      <= '0;
    end else begin
      status <= (status & ~clrVec) | setVec;
      if (hostWr && hostAddr == REG_CTRL) begin
        dirRx     <= hostWdata[0];
        clearBusy <= hostWdata[1];
      end else begin
        clearBusy <= 1'b0;
      end
      if (hostWr && hostAddr == REG_THRES) rxThres <= hostWdata[TW-1:0];
      if (hostWr && hostAddr == REG_MASK)  mask    <= hostWdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      hostRdata <= '0;
    end else if (hostRd) begin
      case (hostAddr)
        REG_CTRL:  hostRdata <= {6'b0, clearBusy, dirRx};
        REG_THRES: hostRdata <= 8'(rxThres);
        REG_STAT:  hostRdata <= status;
        REG_MASK:  hostRdata <= mask;
        REG_DATA:  hostRdata <= (dirRx && stb.pop) ? headData : 8'h00;
        default:   hostRdata <= 8'h00;
      endcase
    end
  end

  assign irq = |(status & mask);

  // R4: an empty read in receive direction raises underflow
  a_r4_underflow_flag: assert property (@(posedge clk) disable iff (!rstN)
    (dataRd && dirRx && empty) |=> status[ST_UNDER]);

  // R3: a full write in transmit direction raises overflow
  a_r3_overflow_flag: assert property (@(posedge clk) disable iff (!rstN)
    (dataWr && !dirRx && full) |=> status[ST_OVER]);

  // R5: wrong-direction access moves nothing in the store
  a_r5_illegal_no_move: assert property (@(posedge clk) disable iff (!rstN)
    (dataWr && dirRx && !engPush) |=> $stable(level));

  // R6: a receive level past the threshold sets the request
  a_r6_rx_request: assert property (@(posedge clk) disable iff (!rstN)
    (dirRx && level > CW'(rxThres)) |=> status[ST_REQ]);

  // R7: an empty transmit FIFO sets the request
  a_r7_tx_request: assert property (@(posedge clk) disable iff (!rstN)
    (!dirRx && empty) |=> status[ST_REQ]);

endmodule

// File: rtl/xfer_fifo_irq.sv
module xfer_fifo_irq
  import xfer_fifo_pkg::*;
#(
  parameter int DEPTH     = 16,
  parameter int INCLUSIVE = 0
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       hostWr,
  input  logic       hostRd,
  input  logic [2:0] hostAddr,
  input  logic [7:0] hostWdata,
  output logic [7:0] hostRdata,
  input  logic       engPush,
  input  logic [7:0] engPushData,
  input  logic       engPop,
  output logic [7:0] engPopData,
  output logic       engFull,
  output logic       engEmpty,
  input  logic       engDone,
  input  logic       engArbLost,
  input  logic       engNack,
  input  logic       engBusFault,
  output logic       irq
);

  localparam int CW = $clog2(DEPTH + 1);

  fifoStrobe_t   stb;
  logic [CW-1:0] level;
  logic          full, empty;
  logic [7:0]    headData;

  xfer_fifo_ctrl #(.DEPTH(DEPTH), .INCLUSIVE(INCLUSIVE), .CW(CW)) ctrl_i (
    .clk, .rstN, .hostWr, .hostRd, .hostAddr, .hostWdata, .hostRdata,
    .engPush, .engPop, .engDone, .engArbLost, .engNack, .engBusFault,
    .level, .full, .empty, .headData, .stb, .irq
  );

  xfer_fifo_store #(.DEPTH(DEPTH), .CW(CW)) store_i (
    .clk, .rstN, .stb, .hostData(hostWdata), .engData(engPushData),
    .headData, .level, .full, .empty
  );

  assign engPopData = headData;
  assign engFull    = full;
  assign engEmpty   = empty;

endmodule

// File: tb/xfer_fifo_irq_tb.sv
module xfer_fifo_irq_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int DEPTH      = 16;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       hostWr = 0, hostRd = 0;
  logic [2:0] hostAddr = 0;
  logic [7:0] hostWdata = 0, hostRdata;
  logic       engPush = 0, engPop = 0;
  logic [7:0] engPushData = 0, engPopData;
  logic       engFull, engEmpty;
  logic       engDone = 0, engArbLost = 0, engNack = 0, engBusFault = 0;
  logic       irq;

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  xfer_fifo_irq #(.DEPTH(DEPTH), .INCLUSIVE(0)) dut_i (
    .clk, .rstN, .hostWr, .hostRd, .hostAddr, .hostWdata, .hostRdata,
    .engPush, .engPushData, .engPop, .engPopData, .engFull, .engEmpty,
    .engDone, .engArbLost, .engNack, .engBusFault, .irq
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic writeReg(input logic [2:0] a, input logic [7:0] d);
    hostWr = 1; hostAddr = a; hostWdata = d;
    @(negedge clk);
    hostWr = 0;
  endtask

  task automatic readReg(input logic [2:0] a, output logic [7:0] d);
    hostRd = 1; hostAddr = a;
    @(negedge clk);
    hostRd = 0;
    d = hostRdata;
  endtask

  task automatic readStat(output logic [7:0] d);
    idle(1);
    readReg(3'd2, d);
  endtask

  task automatic pushEng(input logic [7:0] d);
    engPush = 1; engPushData = d;
    @(negedge clk);
    engPush = 0;
  endtask

  task automatic popEng();
    engPop = 1;
    @(negedge clk);
    engPop = 0;
  endtask

  task automatic t_reset();
    logic [7:0] v;
    check("R1 empty", {7'b0, engEmpty}, 8'h01);
    check("R1 irq", {7'b0, irq}, 8'h00);
    readReg(3'd0, v); check("R1 ctrl", v, 8'h01);
    readReg(3'd1, v); check("R1 thres", v, 8'(DEPTH - 1));
    readReg(3'd2, v); check("R1 status", v, 8'h00);
    readReg(3'd3, v); check("R1 mask", v, 8'h00);
  endtask

  task automatic t_rx_path();
    logic [7:0] v;
    writeReg(3'd1, 8'd2);
    pushEng(8'hA5); pushEng(8'h3C);
    readStat(v); check("R6 level equal threshold no req", v, 8'h00);
    pushEng(8'h7E);
    readStat(v); check("R6 level above threshold req", v, 8'h01);
    readReg(3'd4, v); check("R2 rx byte0", v, 8'hA5);
    readReg(3'd4, v); check("R2 rx byte1", v, 8'h3C);
    readReg(3'd4, v); check("R2 rx byte2", v, 8'h7E);
    readReg(3'd4, v); check("R4 empty read data", v, 8'h00);
    readStat(v); check("R4 underflow bit", v, 8'h09);
    writeReg(3'd2, 8'hFF);
    readStat(v); check("R8 w1c all", v, 8'h00);
  endtask

  task automatic t_illegal_rx();
    logic [7:0] v;
    writeReg(3'd4, 8'h55);
    readStat(v); check("R5 write in rx illegal", v, 8'h04);
    readReg(3'd4, v); check("R5 byte not stored", v, 8'h00);
    readStat(v); check("R5 underflow after illegal", v, 8'h0C);
    writeReg(3'd2, 8'h08);
    readStat(v); check("R8 partial clear", v, 8'h04);
    writeReg(3'd2, 8'hFF);
  endtask

  task automatic t_tx();
    logic [7:0] v;
    writeReg(3'd0, 8'h00);
    readStat(v); check("R7 tx empty req", v, 8'h01);
    writeReg(3'd2, 8'h01);
    readStat(v); check("R8 set wins over clear", v, 8'h01);
    writeReg(3'd4, 8'h10);
    writeReg(3'd2, 8'h01);
    readStat(v); check("R8 clear after fill", v, 8'h00);
    for (int k = 1; k < DEPTH; k++) writeReg(3'd4, 8'h10 + 8'(k));
    check("R3 full flag", {7'b0, engFull}, 8'h01);
    writeReg(3'd4, 8'hEE);
    readStat(v); check("R3 overflow bit", v, 8'h10);
    for (int k = 0; k < DEPTH; k++) begin
      check("R2 tx order", engPopData, 8'h10 + 8'(k));
      popEng();
    end
    check("R3 dropped byte absent", {7'b0, engEmpty}, 8'h01);
    readStat(v); check("R7 req after drain", v, 8'h11);
    writeReg(3'd2, 8'hFF);
    readReg(3'd4, v); check("R5 tx read returns zero", v, 8'h00);
    readStat(v); check("R5 read in tx illegal", v, 8'h05);
    writeReg(3'd2, 8'hFF);
  endtask

  task automatic t_ignore();
    logic [7:0] v;
    pushEng(8'h99);
    check("R12 push ignored in tx", {7'b0, engEmpty}, 8'h01);
    writeReg(3'd0, 8'h01);
    pushEng(8'h42);
    popEng();
    readReg(3'd4, v); check("R12 pop ignored in rx", v, 8'h42);
  endtask

  task automatic t_clear();
    logic [7:0] v;
    writeReg(3'd0, 8'h00);
    writeReg(3'd4, 8'h01); writeReg(3'd4, 8'h02); writeReg(3'd4, 8'h03);
    check("R9 filled", {7'b0, engEmpty}, 8'h00);
    writeReg(3'd0, 8'h02);
    readReg(3'd0, v); check("R9 clear bit busy", v, 8'h02);
    readReg(3'd0, v); check("R9 clear bit done", v, 8'h00);
    check("R9 emptied", {7'b0, engEmpty}, 8'h01);
  endtask

  task automatic t_events_irq();
    logic [7:0] v;
    writeReg(3'd0, 8'h01);
    idle(1);
    writeReg(3'd2, 8'hFF);
    engDone = 1; engArbLost = 1; engNack = 1; engBusFault = 1;
    @(negedge clk);
    engDone = 0; engArbLost = 0; engNack = 0; engBusFault = 0;
    readStat(v); check("R10 event bits", v, 8'hE2);
    check("R11 masked off", {7'b0, irq}, 8'h00);
    writeReg(3'd3, 8'h80);
    check("R11 mask enables irq", {7'b0, irq}, 8'h01);
    writeReg(3'd3, 8'h01);
    check("R11 unmatched mask", {7'b0, irq}, 8'h00);
    writeReg(3'd3, 8'h80);
    writeReg(3'd2, 8'h80);
    check("R11 irq after w1c", {7'b0, irq}, 8'h00);
    readStat(v); check("R8 others kept", v, 8'h62);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      fails++; checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_rx_path();
    t_illegal_rx();
    t_tx();
    t_ignore();
    t_clear();
    t_events_irq();
    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule